// File: doc/BRIEF.md
# Single-bit Boolean processor unit

This unit carries out the single-bit operations of an 8-bit microcontroller core. Each command is a decoded operation code and an 8-bit bit address. The bit address selects one bit out of a 256-bit space. The lower half of that space is backed by a block of internal RAM bytes. The upper half is backed by bit-addressable special-function registers (SFRs).

The carry flag lives inside the unit and acts as the one-bit accumulator. The same flag is also reachable through its own bit address in the status byte. Any access through that address works on the carry register itself, so the carry and the status byte never disagree.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the producer must hold `cmd_valid`, `cmd_op` and `cmd_addr` unchanged.

The unit reaches memory through a byte-wide read-modify-write port. Read data is returned one cycle after `mem_rd_en`. Results come back as a one-cycle `done` pulse, together with the carry and a branch-taken flag that the core's jump logic uses.

Top module: `bitp_unit`

## Requirements
- R1: A bit address below 80h selects RAM (`mem_sfr`=0), byte 20h + addr[6:3], bit addr[2:0].
- R2: A bit address of 80h or above selects SFR space (`mem_sfr`=1), byte {addr[7:3],000b}, bit addr[2:0].
- R3: Bit address D7h is the carry. Any operation on it reads and updates the internal carry and makes no memory access.
- R4: The carry-only operations act on the carry and make no memory access. They are clear carry (code 0), set carry (1) and complement carry (2).
- R5: The bit-write operations are clear bit (3), set bit (4) and complement bit (5). Each does one byte read, then one write of the same byte in which only the selected bit changes.
- R6: The logic operations leave memory unwritten. They are AND bit into carry (6), AND complemented bit (7), OR bit (8) and OR complemented bit (9). The complemented forms leave the stored bit unchanged.
- R7: Code 10 copies the bit into carry. Code 11 writes carry into the bit by read-modify-write.
- R8: Code 12 jumps on bit set and code 13 on bit clear. Code 15 jumps on carry set and code 16 on carry clear. None of them writes memory.
- R9: Code 14 tests the bit and reports taken when it is 1, clearing it in the same operation. When the bit is 0 it is not taken and makes no write.
- R10: Every byte written to the status byte (SFR D0h) carries the current carry in bit 7.
- R11: `cmd_ready` is high only when idle, and each accepted command gives exactly one `done` pulse. That pulse comes 3 cycles after acceptance when memory is used and 2 cycles after otherwise. `taken` is meaningful only with `done` and is 0 for non-jump codes.
- R12: After reset, carry, `taken` and `done` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 5 | Decoded operation code (0..16) |
| cmd_addr | input | 8 | Direct bit address |
| mem_rd_en | output | 1 | Byte read request |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_sfr | output | 1 | 1 = SFR space, 0 = RAM |
| mem_addr | output | 8 | Byte address for read and write |
| mem_wr_data | output | 8 | Byte to write |
| mem_rd_data | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| carry | output | 1 | Carry / bit accumulator |
| taken | output | 1 | Jump condition result, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the producer keeps a pending command steady until the unit takes it. They also assume that the memory returns the addressed byte exactly one cycle after the read strobe, and that only codes 0 to 16 are sent. The bench keeps within these rules in three ways. Its driver raises `cmd_valid` only between falling edges and holds it until the command is taken. Its memory model registers read data on the edge after `mem_rd_en`. Its directed and random operation codes are drawn from the legal range only.

// File: rtl/bitp_pkg.sv
package bitp_pkg;

  typedef enum logic [4:0] {
    OP_CLR_C  = 5'd0,
    OP_SET_C  = 5'd1,
    OP_CPL_C  = 5'd2,
    OP_CLR_B  = 5'd3,
    OP_SET_B  = 5'd4,
    OP_CPL_B  = 5'd5,
    OP_AND_B  = 5'd6,
    OP_AND_NB = 5'd7,
    OP_OR_B   = 5'd8,
    OP_OR_NB  = 5'd9,
    OP_LD_C   = 5'd10,
    OP_ST_C   = 5'd11,
    OP_J_SET  = 5'd12,
    OP_J_CLR  = 5'd13,
    OP_J_TCLR = 5'd14,
    OP_J_CY   = 5'd15,
    OP_J_NCY  = 5'd16
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_EX
  } bseq_e;

  function automatic logic carry_only(input bop_e op);
    return op inside {OP_CLR_C, OP_SET_C, OP_CPL_C, OP_J_CY, OP_J_NCY};
  endfunction

  function automatic logic is_jump(input bop_e op);
    return op inside {OP_J_SET, OP_J_CLR, OP_J_TCLR, OP_J_CY, OP_J_NCY};
  endfunction

endpackage

// File: rtl/bitp_addr_map.sv
module bitp_addr_map #(
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  RAM_BASE = 8'h20,
  parameter logic [7:0]  PSW_BYTE = 8'hD0,
  parameter logic [2:0]  CY_POS   = 3'd7
) (
  input  logic [AW-1:0] bit_addr,
  output logic [7:0]    byte_addr,
  output logic [2:0]    bit_idx,
  output logic          is_sfr,
  output logic          is_psw,
  output logic          is_carry
);
  localparam int unsigned RW = AW - 4;

  always_comb begin
    bit_idx = bit_addr[2:0];
    is_sfr  = bit_addr[AW-1];
    if (is_sfr) begin
      byte_addr = {bit_addr[AW-1:3], 3'b000};
    end else begin
      byte_addr = RAM_BASE + {{(8-RW){1'b0}}, bit_addr[AW-2:3]};
    end
    is_psw   = is_sfr && (byte_addr == PSW_BYTE);
    is_carry = is_psw && (bit_idx == CY_POS);
  end

endmodule

// File: rtl/bitp_alu.sv
module bitp_alu
  import bitp_pkg::*;
(
  input  bop_e op,
  input  logic bit_val,
  input  logic cy,
  output logic new_cy,
  output logic new_bit,
  output logic wr_bit,
  output logic take
);
  always_comb begin
    new_cy  = cy;
    new_bit = bit_val;
    wr_bit  = 1'b0;
    take    = 1'b0;
    unique case (op)
      OP_CLR_C:  new_cy = 1'b0;
      OP_SET_C:  new_cy = 1'b1;
      OP_CPL_C:  new_cy = ~cy;
      OP_CLR_B:  begin new_bit = 1'b0;     wr_bit = 1'b1; end
      OP_SET_B:  begin new_bit = 1'b1;     wr_bit = 1'b1; end
      OP_CPL_B:  begin new_bit = ~bit_val; wr_bit = 1'b1; end
      OP_AND_B:  new_cy = cy & bit_val;
      OP_AND_NB: new_cy = cy & ~bit_val;
      OP_OR_B:   new_cy = cy | bit_val;
      OP_OR_NB:  new_cy = cy | ~bit_val;
      OP_LD_C:   new_cy = bit_val;
      OP_ST_C:   begin new_bit = cy; wr_bit = 1'b1; end
      OP_J_SET:  take = bit_val;
      OP_J_CLR:  take = ~bit_val;
      OP_J_TCLR: begin
        take    = bit_val;
        new_bit = 1'b0;
        wr_bit  = bit_val;
      end
      OP_J_CY:   take = cy;
      OP_J_NCY:  take = ~cy;
      default:   ;
    endcase
  end
endmodule

// File: rtl/bitp_seq.sv
module bitp_seq
  import bitp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic need_mem,
  output logic cmd_ready,
  output logic accept,
  output logic rd_en,
  output logic ex,
  output logic done
);
  bseq_e st;

  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign rd_en     = (st == ST_RD);
  assign ex        = (st == ST_EX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= (st == ST_EX);
      unique case (st)
        ST_IDLE: if (accept) st <= need_mem ? ST_RD : ST_EX;
        ST_RD:   st <= ST_EX;
        ST_EX:   st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_read_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (ex && !cmd_ready));
  a_r11_exec_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    ex |=> (done && cmd_ready));

endmodule

// File: rtl/bitp_unit.sv
module bitp_unit
  import bitp_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  RAM_BASE = 8'h20,
  parameter logic [7:0]  PSW_BYTE = 8'hD0,
  parameter logic [2:0]  CY_POS   = 3'd7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [4:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          mem_sfr,
  output logic [7:0]    mem_addr,
  output logic [7:0]    mem_wr_data,
  input  logic [7:0]    mem_rd_data,
  output logic          carry,
  output logic          taken,
  output logic          done
);
  localparam logic [AW-1:0] CY_BIT_ADDR = AW'(PSW_BYTE | {5'b0, CY_POS});

  bop_e          op_q;
  logic [AW-1:0] addr_q;
  logic          need_q;
  logic          cy_q;
  logic          tk_q;
  logic          accept, ex, need_in;
  logic [2:0]    bit_idx;
  logic          is_psw, is_cy;
  logic          bit_val, new_cy, new_bit, wr_bit, take;
  logic [7:0]    wr_byte;

  assign need_in = !carry_only(bop_e'(cmd_op)) && (cmd_addr != CY_BIT_ADDR);

  bitp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .need_mem  (need_in),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .rd_en     (mem_rd_en),
    .ex        (ex),
    .done      (done)
  );

  bitp_addr_map #(
    .AW       (AW),
    .RAM_BASE (RAM_BASE),
    .PSW_BYTE (PSW_BYTE),
    .CY_POS   (CY_POS)
  ) u_map (
    .bit_addr  (addr_q),
    .byte_addr (mem_addr),
    .bit_idx   (bit_idx),
    .is_sfr    (mem_sfr),
    .is_psw    (is_psw),
    .is_carry  (is_cy)
  );

  assign bit_val = is_cy ? cy_q : mem_rd_data[bit_idx];

  bitp_alu u_alu (
    .op      (op_q),
    .bit_val (bit_val),
    .cy      (cy_q),
    .new_cy  (new_cy),
    .new_bit (new_bit),
    .wr_bit  (wr_bit),
    .take    (take)
  );

  always_comb begin
    wr_byte          = mem_rd_data;
    wr_byte[bit_idx] = new_bit;
    if (is_psw) wr_byte[CY_POS] = cy_q;
  end

  assign mem_wr_en   = ex && need_q && wr_bit;
  assign mem_wr_data = wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_CLR_C;
      addr_q <= '0;
      need_q <= 1'b0;
      cy_q   <= 1'b0;
      tk_q   <= 1'b0;
    end else begin
      if (accept) begin
        op_q   <= bop_e'(cmd_op);
        addr_q <= cmd_addr;
        need_q <= need_in;
      end
      if (ex) begin
        cy_q <= (is_cy && wr_bit) ? new_bit : new_cy;
        tk_q <= take;
      end
    end
  end

  assign carry = cy_q;
  assign taken = tk_q;

  a_r11_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && $stable(mem_addr) && $stable(mem_sfr)));
  a_r6_logic_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && op_q inside {OP_AND_B, OP_AND_NB, OP_OR_B, OP_OR_NB}) |-> !mem_wr_en);
  a_r8_taken_jump_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken) |-> is_jump(op_q));
  a_r9_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && op_q == OP_J_TCLR) |-> (!mem_wr_data[bit_idx] && mem_rd_data[bit_idx]));
  a_r10_psw_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_sfr && mem_addr == PSW_BYTE) |-> (mem_wr_data[CY_POS] == carry));
  a_r3_carry_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_addr == CY_BIT_ADDR) |=> !mem_rd_en);

endmodule

// File: tb/bitp_unit_bench.sv
`timescale 1ns/1ps
module bitp_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [4:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0;
  logic       cmd_ready, mem_rd_en, mem_wr_en, mem_sfr;
  logic [7:0] mem_addr, mem_wr_data;
  logic [7:0] mem_rd_data = '0;
  logic       carry, taken, done;

  always #4 clk = ~clk;

  bitp_unit u_bitp_unit (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_addr (cmd_addr),
    .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en), .mem_sfr (mem_sfr),
    .mem_addr (mem_addr), .mem_wr_data (mem_wr_data), .mem_rd_data (mem_rd_data),
    .carry (carry), .taken (taken), .done (done)
  );

  logic [7:0] ram [256];
  logic [7:0] sfr [256];
  logic [7:0] m_ram [256];
  logic [7:0] m_sfr [256];
  logic       m_c;

  always @(posedge clk) begin
    if (mem_wr_en) begin
      if (mem_sfr) sfr[mem_addr] <= mem_wr_data;
      else         ram[mem_addr] <= mem_wr_data;
    end
    if (mem_rd_en) mem_rd_data <= mem_sfr ? sfr[mem_addr] : ram[mem_addr];
  end

  typedef struct {
    logic  c;
    logic  tk;
    int    nrd;
    int    nwr;
    string req;
  } exp_t;
  exp_t q[$];

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  bit ended   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops scoreboard items on each done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) rd_cnt++;
      if (mem_wr_en) wr_cnt++;
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R11 spurious done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(carry == e.c, {e.req, " carry"}, carry, e.c);
          chk(taken == e.tk, {e.req, " taken"}, taken, e.tk);
          chk(rd_cnt == e.nrd, {e.req, " reads"}, rd_cnt, e.nrd);
          chk(wr_cnt == e.nwr, {e.req, " writes"}, wr_cnt, e.nwr);
        end
        rd_cnt = 0;
        wr_cnt = 0;
      end
    end
  end

  task automatic run(input int op, input logic [7:0] addr, input string req);
    logic       co, isc, mem, sf, bv, nc, nb, wr, tk;
    logic [7:0] ba, b;
    logic [2:0] idx;
    exp_t       e;
    int         lat;
    co  = (op inside {0, 1, 2, 15, 16});
    isc = (addr == 8'hD7);
    mem = !co && !isc;
    sf  = addr[7];
    ba  = sf ? {addr[7:3], 3'b000} : (8'h20 + {4'b0, addr[6:3]});
    idx = addr[2:0];
    b   = sf ? m_sfr[ba] : m_ram[ba];
    bv  = isc ? m_c : b[idx];
    nc = m_c; nb = bv; wr = 0; tk = 0;
    case (op)
      0:  nc = 0;
      1:  nc = 1;
      2:  nc = ~m_c;
      3:  begin nb = 0; wr = 1; end
      4:  begin nb = 1; wr = 1; end
      5:  begin nb = ~bv; wr = 1; end
      6:  nc = m_c & bv;
      7:  nc = m_c & ~bv;
      8:  nc = m_c | bv;
      9:  nc = m_c | ~bv;
      10: nc = bv;
      11: begin nb = m_c; wr = 1; end
      12: tk = bv;
      13: tk = ~bv;
      14: begin tk = bv; if (bv) begin nb = 0; wr = 1; end end
      15: tk = m_c;
      16: tk = ~m_c;
      default: ;
    endcase
    if (wr) begin
      if (isc) nc = nb;
      else begin
        b[idx] = nb;
        if (sf && ba == 8'hD0) b[7] = m_c;
        if (sf) m_sfr[ba] = b; else m_ram[ba] = b;
      end
    end
    m_c = nc;
    e.c = nc; e.tk = tk; e.nrd = mem ? 1 : 0; e.nwr = (mem && wr) ? 1 : 0; e.req = req;
    q.push_back(e);
    cmd_op = op[4:0]; cmd_addr = addr; cmd_valid = 1'b1;
    do @(posedge clk); while (!cmd_ready);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R11 ready low while busy", cmd_ready, 0);
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == (mem ? 3 : 2), {req, " R11 latency"}, lat, mem ? 3 : 2);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]   = 8'(i * 37 + 5);
      sfr[i]   = 8'(i * 91 + 3);
      m_ram[i] = ram[i];
      m_sfr[i] = sfr[i];
    end
    m_c = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(carry == 0, "R12 carry", carry, 0);
    chk(taken == 0, "R12 taken", taken, 0);
    chk(done == 0, "R12 done", done, 0);
    chk(cmd_ready == 1, "R12 ready", cmd_ready, 1);
    // R4 carry-only
    run(1, 8'h00, "R4 set carry");
    run(2, 8'h00, "R4 cpl carry");
    run(2, 8'h40, "R4 cpl carry again");
    run(0, 8'h90, "R4 clr carry");
    // R1 RAM map, R5 writes
    run(4, 8'h05, "R1 R5 set ram bit");
    run(3, 8'h7F, "R1 R5 clr ram top bit");
    run(5, 8'h3A, "R1 R5 cpl ram bit");
    // R2 SFR map
    run(5, 8'h90, "R2 R5 cpl sfr bit");
    run(4, 8'hFF, "R2 R5 set sfr top bit");
    // R7 moves
    run(10, 8'h05, "R7 load carry from bit");
    run(11, 8'h91, "R7 store carry to bit");
    run(0, 8'h00, "R4 clr carry");
    run(11, 8'h91, "R7 store zero carry");
    // R6 logic, complemented forms
    run(1, 8'h00, "R4 set carry");
    run(6, 8'h05, "R6 and bit");
    run(7, 8'h05, "R6 and complemented bit");
    run(9, 8'h7F, "R6 or complemented bit");
    run(8, 8'h7F, "R6 or bit");
    run(12, 8'h05, "R6 complemented source kept");
    // R8 jumps
    run(12, 8'h7F, "R8 jump on set (clear)");
    run(13, 8'h7F, "R8 jump on clear");
    run(15, 8'h00, "R8 jump on carry");
    run(16, 8'h00, "R8 jump on no carry");
    // R9 test and clear
    run(14, 8'h05, "R9 test-clear set bit");
    run(14, 8'h05, "R9 test-clear clear bit");
    run(12, 8'h05, "R9 bit now clear");
    // R3 carry bit address
    run(3, 8'hD7, "R3 clr via bit addr");
    run(4, 8'hD7, "R3 set via bit addr");
    run(5, 8'hD7, "R3 cpl via bit addr");
    run(4, 8'hD7, "R3 set via bit addr");
    run(14, 8'hD7, "R3 test-clear carry");
    run(10, 8'hD7, "R3 load carry from itself");
    // R10 status byte coherence
    run(1, 8'h00, "R4 set carry");
    run(4, 8'hD5, "R10 status bit with carry 1");
    run(0, 8'h00, "R4 clr carry");
    run(5, 8'hD2, "R10 status bit with carry 0");
    run(12, 8'hD0, "R8 status bit test");
    // mixed random
    for (int k = 0; k < 300; k++) begin
      int         op;
      logic [7:0] a;
      op = $urandom_range(0, 16);
      case ($urandom_range(0, 3))
        0: a = 8'($urandom_range(0, 127));
        1: a = 8'($urandom_range(128, 255));
        2: a = 8'hD7;
        default: a = 8'hD0 + 8'($urandom_range(0, 7));
      endcase
      run(op, a, "R11 random mix");
    end
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 all results seen", q.size(), 0);
    for (int i = 0; i < 16; i++)
      chk(ram[8'h20 + i] == m_ram[8'h20 + i], "R1 R5 ram byte", ram[8'h20 + i], m_ram[8'h20 + i]);
    for (int i = 16; i < 32; i++)
      chk(sfr[i * 8] == m_sfr[i * 8], "R2 R10 sfr byte", sfr[i * 8], m_sfr[i * 8]);
    summary();
  end
endmodule